// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked user port and an external asynchronous static RAM with a 20-bit address, an 8-bit data bus and active-low select, output-enable and write-strobe pins. It accepts one single-word read or write at a time through a valid/ready handshake. It then produces the pin sequence the RAM needs, with every phase lasting a whole number of clock cycles. Each phase length is derived at elaboration from nanosecond minimums and the clock period parameter, always rounded up.

A read drives select and output-enable low and samples the RAM data once the access time has elapsed. The sampled byte is returned through a one-cycle response strobe. A write lowers select and the write strobe together, and first waits for the RAM to release the bus. It then drives the data, and ends the write by raising the strobe in the same cycle that its own bus driver turns off. After reset the block keeps the RAM idle for the supply settling time before it reports ready.

Top module: `asram_ctrl`

## Requirements
- R1: After reset release, `req_ready` stays low and all three strobes stay high with `mem_dq_oe` low. `req_ready` first rises in clock cycle ceil(T_PWRUP_PS/CLK_PS)+1. Requests presented before that have no effect, and a later read of their address returns the old contents.
- R2: In every cycle with `req_ready` high, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1 and `mem_dq_oe` is 0. At least one such cycle separates two accesses.
- R3: An accepted read holds `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and the accepted address on `mem_addr` for RD = ceil(max(T_CYC_PS, T_ACC_PS, T_OE_ACC_PS)/CLK_PS) cycles, beginning in the cycle after acceptance.
- R4: The byte on `mem_dq_in` at the clock edge that ends the last read cycle appears on `rsp_rdata`, with `rsp_valid`=1 for exactly the following cycle.
- R5: An accepted write first spends TURN = max(1, ceil(T_RELEASE_PS/CLK_PS)) cycles with `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R6: The write then spends WD = max(ceil(T_DSETUP_PS/CLK_PS), ceil(max(T_WPULSE_PS,T_CYC_PS)/CLK_PS) − TURN) cycles with `mem_dq_oe`=1 and `mem_dq_out` equal to the accepted data. `mem_we_n` and `mem_ce_n` rise in the same cycle that `mem_dq_oe` falls, and the address is held through the whole write.
- R7: A write never produces a `rsp_valid` pulse.
- R8: While `req_ready` is low, `req_valid` and the request fields are ignored, and no access starts from them.
- R9: The controller never drives the data bus while the RAM may still be driving it. With the bench model's limits, the write pulse is at least ceil(7 ns) long and the data setup at least ceil(5 ns) long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | DATA_W | Data seen on the RAM bus |

## Verification
The bench builds the controller with CLK_PS = 3000 and keeps the nanosecond limits at their defaults. This gives a 4-cycle read, a 2-cycle bus release, a 2-cycle data phase and a 33334-cycle power-up hold. Multi-cycle phases, the read-to-write turnaround and early sampling therefore become observable; the 10 ns default collapses each of them to a single cycle. The RAM model returns corrupted bytes until its access count is reached and keeps driving the bus for the release time after a read. It uses a 6-bit index, so early capture, a short turnaround or a short write pulse each shows up at the ports.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_READ,
    ST_WTURN,
    ST_WDATA
  } ctl_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // pin levels held while the controller sits in a given state
  function automatic strobe_t strobe_of(input ctl_state_e st);
    strobe_t s;
    s = STROBE_OFF;
    case (st)
      ST_READ: begin
        s.ce_n = 1'b0;
        s.oe_n = 1'b0;
      end
      ST_WTURN: begin
        s.ce_n = 1'b0;
        s.we_n = 1'b0;
      end
      ST_WDATA: begin
        s.ce_n = 1'b0;
        s.we_n = 1'b0;
        s.drv  = 1'b1;
      end
      default: s = STROBE_OFF;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/asram_pwrup_wait.sv
`timescale 1ns/1ps
module asram_pwrup_wait #(
  parameter int WAIT_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == CW'(WAIT_CYC));
  assign cnt_en = !done;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/asram_rd_capture.sv
`timescale 1ns/1ps
module asram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              valid
);

  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (capture) begin
      data_q <= dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
    end
  end

  assign rdata = data_q;
  assign valid = valid_q;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 8,
  parameter int CLK_PS       = 10000,
  parameter int T_PWRUP_PS   = 100_000_000,
  parameter int T_CYC_PS     = 10000,
  parameter int T_ACC_PS     = 10000,
  parameter int T_OE_ACC_PS  = 5000,
  parameter int T_WPULSE_PS  = 7000,
  parameter int T_DSETUP_PS  = 5000,
  parameter int T_RELEASE_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // phase lengths in cycles, each minimum rounded up
  localparam int RD_CYC   = ps_to_cyc(imax(imax(T_CYC_PS, T_ACC_PS), T_OE_ACC_PS), CLK_PS);
  localparam int TURN_CYC = imax(1, ps_to_cyc(T_RELEASE_PS, CLK_PS));
  localparam int PW_CYC   = ps_to_cyc(imax(T_WPULSE_PS, T_CYC_PS), CLK_PS);
  localparam int SD_CYC   = imax(1, ps_to_cyc(T_DSETUP_PS, CLK_PS));
  localparam int WD_CYC   = imax(SD_CYC, PW_CYC - TURN_CYC);
  localparam int PWR_CYC  = ps_to_cyc(T_PWRUP_PS, CLK_PS);
  localparam int PH_MAX   = imax(imax(RD_CYC, TURN_CYC), WD_CYC);
  localparam int CNT_W    = $clog2(PH_MAX + 1);

  ctl_state_e        state_q, state_d;
  strobe_t           strobe_q, strobe_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  logic              capture;
  logic              ph_load;
  logic [CNT_W-1:0]  ph_val;
  logic              ph_expired;
  logic              pwr_done;

  asram_pwrup_wait #(.WAIT_CYC(PWR_CYC)) u_pwrup (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (pwr_done)
  );

  asram_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .expired  (ph_expired)
  );

  asram_rd_capture #(.DATA_W(DATA_W)) u_rcap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .dq_in   (mem_dq_in),
    .rdata   (rsp_rdata),
    .valid   (rsp_valid)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    ph_load = 1'b0;
    ph_val  = '0;
    case (state_q)
      ST_PWR: begin
        if (pwr_done) begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          ph_load = 1'b1;
          if (req_write) begin
            state_d = ST_WTURN;
            ph_val  = CNT_W'(TURN_CYC - 1);
          end else begin
            state_d = ST_READ;
            ph_val  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (ph_expired) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WTURN: begin
        if (ph_expired) begin
          state_d = ST_WDATA;
          ph_load = 1'b1;
          ph_val  = CNT_W'(WD_CYC - 1);
        end
      end
      ST_WDATA: begin
        if (ph_expired) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_PWR;
    endcase
    strobe_d = strobe_of(state_d);
  end

  // state and registered pin levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PWR;
      strobe_q <= STROBE_OFF;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
    end
  end

  // request fields, loaded on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_ce_n   = strobe_q.ce_n;
  assign mem_oe_n   = strobe_q.oe_n;
  assign mem_we_n   = strobe_q.we_n;
  assign mem_dq_oe  = strobe_q.drv;
  assign mem_dq_out = wdata_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W  = 20,
  parameter int PWR_CYC = 1,
  parameter int PW_CYC  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  int pw_cnt;
  int wl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_cnt <= 0;
    end else if (pw_cnt < PWR_CYC) begin
      pw_cnt <= pw_cnt + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_cnt <= 0;
    end else if (mem_we_n) begin
      wl_cnt <= 0;
    end else begin
      wl_cnt <= wl_cnt + 1;
    end
  end

  p_pwr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pw_cnt >= PWR_CYC));

  p_idle_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_drv_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

  p_we_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($fell(mem_dq_oe) && (wl_cnt >= PW_CYC)));

  p_no_rsp_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !rsp_valid);

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  p_no_drive_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .PWR_CYC (PWR_CYC),
  .PW_CYC  (PW_CYC)
) u_chk (.*);

// File: tb/tb_sram_model.sv
`timescale 1ns/1ps
module tb_sram_model #(
  parameter int AW      = 20,
  parameter int DW      = 8,
  parameter int IDX_W   = 6,
  parameter int ACC_CYC = 1,
  parameter int REL_CYC = 1,
  parameter int PW_CYC  = 1,
  parameter int SD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] d_in,
  input  logic          d_oe,
  output logic [DW-1:0] q,
  output logic          drive,
  output int            viol
);

  logic [DW-1:0]    mem [1<<IDX_W];
  int               rd_cnt;
  int               hz;
  int               wl;
  int               dd;
  logic [AW-1:0]    la;
  logic [DW-1:0]    ld;
  logic             lo;
  logic             rd, wr;
  logic [3:0]       bad;
  logic [IDX_W-1:0] idx;

  assign idx = a[IDX_W-1:0];

  always_comb begin
    rd    = !ce_n && !oe_n && we_n;
    wr    = !ce_n && !we_n;
    drive = rd || (hz != 0);
    q     = (rd && rd_cnt >= ACC_CYC - 1) ? mem[idx] : ~mem[idx];
    bad   = {d_oe && drive,
             d_oe && !wr,
             wr && (wl != 0) && (a != la),
             !wr && (wl != 0) && ((wl < PW_CYC) || (dd < SD_CYC) || !lo)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << IDX_W); i++) mem[i] <= DW'(i * 37 + 11);
      rd_cnt <= 0; hz <= 0; wl <= 0; dd <= 0; viol <= 0;
      la <= '0; ld <= '0; lo <= 1'b0;
    end else begin
      viol   <= viol + $countones(bad);
      rd_cnt <= rd ? rd_cnt + 1 : 0;
      hz     <= rd ? REL_CYC : ((hz > 0) ? hz - 1 : 0);
      if (wr) begin
        wl <= wl + 1;
        dd <= d_oe ? dd + 1 : dd;
        la <= a;
        ld <= d_in;
        lo <= d_oe;
      end else if (wl != 0) begin
        mem[la[IDX_W-1:0]] <= ld;
        wl <= 0;
        dd <= 0;
      end
    end
  end

endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam int AW     = 20;
  localparam int DW     = 8;
  localparam int CPS    = 3000;
  localparam int RD_N   = (10000 + CPS - 1) / CPS;
  localparam int TURN_N = (5000 + CPS - 1) / CPS;
  localparam int SD_N   = (5000 + CPS - 1) / CPS;
  localparam int PWE_N  = (7000 + CPS - 1) / CPS;
  localparam int PW_N   = (10000 + CPS - 1) / CPS;
  localparam int WD_N   = (SD_N > PW_N - TURN_N) ? SD_N : PW_N - TURN_N;
  localparam int PWR_N  = (100_000_000 + CPS - 1) / CPS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic [DW-1:0] m_q;
  logic          m_drive;
  int            m_viol;

  always #10 clk = ~clk;

  asram_ctrl #(.CLK_PS(CPS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  tb_sram_model #(.AW(AW), .DW(DW), .IDX_W(6), .ACC_CYC(RD_N), .REL_CYC(TURN_N),
                  .PW_CYC(PWE_N), .SD_CYC(SD_N)) u_mem (
    .clk(clk), .rst_n(rst_n), .a(mem_addr), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
    .we_n(mem_we_n), .d_in(mem_dq_out), .d_oe(mem_dq_oe),
    .q(m_q), .drive(m_drive), .viol(m_viol)
  );

  assign mem_dq_in = m_drive ? m_q : (mem_dq_oe ? mem_dq_out : '0);

  typedef struct {
    bit            ce, oe, we, drv, rdy, rv;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t          e;
  exp_t          q_exp[$];
  logic [DW-1:0] refm [64];
  int            edges;
  int            n_chk;
  int            n_bad;
  bit            finished;

  function automatic exp_t mk(bit ce, bit oe, bit we, bit drv, bit rdy, bit rv,
                              logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    exp_t x;
    x.ce = ce; x.oe = oe; x.we = we; x.drv = drv; x.rdy = rdy; x.rv = rv;
    x.a = a; x.d = d; x.tag = tag;
    return x;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, expv, edges);
    end
  endtask

  task automatic compare();
    chk(mem_ce_n  == e.ce,  e.tag, "ce_n",  mem_ce_n,  e.ce);
    chk(mem_oe_n  == e.oe,  e.tag, "oe_n",  mem_oe_n,  e.oe);
    chk(mem_we_n  == e.we,  e.tag, "we_n",  mem_we_n,  e.we);
    chk(mem_dq_oe == e.drv, e.tag, "dq_oe", mem_dq_oe, e.drv);
    chk(req_ready == e.rdy, e.tag, "ready", req_ready, e.rdy);
    chk(rsp_valid == e.rv,  e.tag, "rsp_valid", rsp_valid, e.rv);
    if (e.rv)   chk(rsp_rdata  == e.d, e.tag, "rsp_rdata", rsp_rdata, e.d);
    if (!e.ce)  chk(mem_addr   == e.a, e.tag, "mem_addr", mem_addr, e.a);
    if (e.drv)  chk(mem_dq_out == e.d, e.tag, "dq_out", mem_dq_out, e.d);
  endtask

  // one clock of the reference: decide next expectation, advance, compare
  task automatic tick();
    exp_t nx;
    bit   pwr_next;
    if (e.rdy && req_valid) begin
      if (req_write) begin
        repeat (TURN_N) q_exp.push_back(mk(0, 1, 0, 0, 0, 0, req_addr, req_wdata, "R5"));
        repeat (WD_N)   q_exp.push_back(mk(0, 1, 0, 1, 0, 0, req_addr, req_wdata, "R6"));
        q_exp.push_back(mk(1, 1, 1, 0, 1, 0, req_addr, '0, "R7"));
        refm[req_addr[5:0]] = req_wdata;
      end else begin
        repeat (RD_N) q_exp.push_back(mk(0, 0, 1, 0, 0, 0, req_addr, '0, "R3"));
        q_exp.push_back(mk(1, 1, 1, 0, 1, 1, req_addr, refm[req_addr[5:0]], "R4"));
      end
    end
    pwr_next = (edges + 1 >= PWR_N + 1);
    if (q_exp.size() > 0) nx = q_exp.pop_front();
    else nx = mk(1, 1, 1, 0, pwr_next, 0, '0, '0, pwr_next ? "R2" : "R1");
    if (req_valid && !e.rdy && pwr_next) nx.tag = "R8";
    @(posedge clk);
    edges++;
    @(negedge clk);
    e = nx;
    compare();
  endtask

  task automatic issue(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    bit took;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    do begin
      took = e.rdy;
      tick();
    end while (!took);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", edges, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; edges = 0; finished = 0;
    for (int i = 0; i < 64; i++) refm[i] = DW'(i * 37 + 11);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    e = mk(1, 1, 1, 0, 0, 0, '0, '0, "R1");
    compare();
    rst_n = 1'b1;

    // R1: power-up hold; a write offered during it must not take effect
    while (!e.rdy) begin
      if (edges == 100) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00015; req_wdata = 8'hEE;
      end
      if (edges == 200) req_valid = 1'b0;
      tick();
    end
    chk(edges == PWR_N + 1, "R1", "ready cycle", edges, PWR_N + 1);

    // back-to-back traffic with req held high through busy cycles (R8)
    issue(1, 20'hABC01, 8'h3C);
    issue(0, 20'hABC01, 8'h00);
    issue(0, 20'h00015, 8'h00);   // R1: pattern, not 0xEE
    issue(1, 20'h12345, 8'hA5);
    issue(1, 20'h00046, 8'h5A);
    issue(0, 20'h12345, 8'h00);
    issue(1, 20'h7FFC2, 8'hFF);   // R5: write right after a read
    issue(0, 20'h00046, 8'h00);
    issue(0, 20'h7FFC2, 8'h00);
    issue(0, 20'hFFFFF, 8'h00);
    issue(1, 20'h00000, 8'h00);
    issue(0, 20'h00000, 8'h00);
    req_valid = 1'b0;
    repeat (4) tick();

    // R8: a write offered only while busy is dropped
    issue(0, 20'h00015, 8'h00);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00015; req_wdata = 8'h77;
    tick();
    req_valid = 1'b0;
    repeat (RD_N + 2) tick();
    issue(0, 20'h00015, 8'h00);
    req_valid = 1'b0;

    // isolated write then read with idle gaps
    repeat (3) tick();
    issue(1, 20'h5A5A9, 8'hC3);
    req_valid = 1'b0;
    repeat (5) tick();
    issue(0, 20'h5A5A9, 8'h00);
    req_valid = 1'b0;
    repeat (RD_N + 4) tick();

    // R9: bus ownership and write windows as seen by the RAM model
    chk(m_viol == 0, "R9", "model violations", m_viol, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule